// File: doc/BRIEF.md
# Unaligned Load Splitter

This block sits between a load pipeline and a memory that only delivers whole aligned 32-bit words. A load of one, two or four bytes may start at any byte address. The block turns each load into the word reads it needs and returns the requested bytes in the low end of the result. If all of the bytes lie inside one aligned word, it reads that word once and shifts it down. If the bytes cross into the next word, it reads the two neighbouring words on back-to-back cycles. It shifts the lower word right and the upper word left, then ORs them together.

Requests arrive through a valid/ready handshake. The block takes one request at a time: it does not accept a new load until the result of the current one has been returned as a one-cycle pulse. A saturating counter counts every word read issued to memory. This shows whether an access cost one read or two.

Top module: `ula_load_split`

## Requirements
- R1: Every memory read is issued at a word address whose two low bits are zero. The first read of a load goes to the load's byte address with bits [1:0] cleared.
- R2: A load whose byte offset (address bits [1:0]) plus its byte count exceeds 4 is split. It issues exactly two reads on consecutive cycles, the second to the first word address plus 4 (the sum wraps within the 32-bit address). Any other load issues exactly one read.
- R3: Memory words are little-endian: byte k of a word is bits [8k+7:8k]. Result byte i (bits [8i+7:8i]) holds the memory byte at load address + i.
- R4: Result bits above the requested byte count are zero.
- R5: The size field encodes the byte count as 00 = 1 byte, 01 = 2 bytes and 10 = 4 bytes. The unused code 11 is handled as a 4-byte load.
- R6: `req_ready` is high only while no load is in progress. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` has no effect while `req_ready` is low. Each accepted load produces exactly one result, and `rsp_valid` is high for a single cycle.
- R7: Memory read data arrives one cycle after the read is issued. `rsp_valid` is high in the third cycle after the accepting edge for an unsplit load, and in the fourth cycle for a split load.
- R8: `txn_count` goes up by one for each cycle in which `mem_rd_en` is high. It holds at its all-ones maximum once it gets there.
- R9: During and right after reset, `req_ready` is 1, `rsp_valid` and `mem_rd_en` are 0, and `txn_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the load |
| req_size | input | 2 | Byte count code (00=1, 01=2, 10/11=4) |
| mem_rd_en | output | 1 | Word read strobe to memory |
| mem_rd_addr | output | ADDR_W | Aligned word address of the read |
| mem_rd_data | input | DATA_W | Read word, valid one cycle after the strobe |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_data | output | DATA_W | Loaded bytes, right-justified, zero-filled |
| txn_count | output | CNT_W | Saturating count of word reads issued |

## Verification
Every combination of the four byte offsets and the four size codes is run through the design. This separates the loads that fit inside one word from those that cross into the next word, at the exact offset where each size starts to split. It also catches an off-by-one in the split test or in the shift amounts. Two extra cases are checked: a load that wraps past the top of the address space, and a request held high while the block is busy. These show that the second word address wraps correctly and that a waiting request is neither taken nor answered. A long run of pseudo-random addresses and sizes, issued back to back, checks data, read count, read addresses and latency on every load. The same run drives the read counter into saturation.

// File: rtl/ula_pkg.sv
package ula_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_RD1,
        ST_FIN,
        ST_RESP
    } ula_state_e;

endpackage

// File: rtl/ula_split_calc.sv
// Decodes a byte-addressed load into its word address, byte offset,
// byte count and whether it crosses into the next word.
module ula_split_calc #(
    parameter int ADDR_W = 32,
    parameter int NBYTES = 4,
    parameter int OFF_W  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [OFF_W-1:0]  off,
    output logic [OFF_W:0]    nbytes,
    output logic              split
);
    localparam logic [OFF_W:0] NB_FULL = (OFF_W+1)'(NBYTES);

    always_comb begin
        off       = addr[OFF_W-1:0];
        word_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        unique case (size)
            2'b00:   nbytes = (OFF_W+1)'(1);
            2'b01:   nbytes = (OFF_W+1)'(2);
            default: nbytes = NB_FULL;
        endcase
        split = ({1'b0, off} + nbytes) > NB_FULL;
    end

endmodule

// File: rtl/ula_merge.sv
// Shifts the low word down, shifts the high word up when the load is split,
// ORs the parts together and clears bytes beyond the requested count.
module ula_merge #(
    parameter int DATA_W = 32,
    parameter int NBYTES = 4,
    parameter int OFF_W  = 2
) (
    input  logic [DATA_W-1:0] w_lo,
    input  logic [DATA_W-1:0] w_hi,
    input  logic [OFF_W-1:0]  off,
    input  logic [OFF_W:0]    nbytes,
    input  logic              split,
    output logic [DATA_W-1:0] data
);
    localparam logic [OFF_W:0] NB_FULL = (OFF_W+1)'(NBYTES);

    logic [DATA_W-1:0] byte_mask;
    logic [DATA_W-1:0] lo_part;
    logic [DATA_W-1:0] hi_part;
    logic [OFF_W:0]    rem;

    for (genvar b = 0; b < NBYTES; b++) begin : g_mask
        assign byte_mask[8*b +: 8] = {8{(OFF_W+1)'(b) < nbytes}};
    end

    always_comb begin
        rem     = NB_FULL - {1'b0, off};
        lo_part = w_lo >> {off, 3'b000};
        hi_part = split ? (w_hi << {rem, 3'b000}) : '0;
        data    = (lo_part | hi_part) & byte_mask;
    end

endmodule

// File: rtl/ula_sat_ctr.sv
// Saturating event counter.
module ula_sat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && (cnt_q != {W{1'b1}})) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/ula_load_split.sv
module ula_load_split #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [CNT_W-1:0]  txn_count
);
    import ula_pkg::*;

    localparam int NBYTES = DATA_W / 8;
    localparam int OFF_W  = $clog2(NBYTES);
    localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(NBYTES);

    typedef struct packed {
        ula_state_e         st;
        logic [ADDR_W-1:0]  waddr;
        logic [OFF_W-1:0]   off;
        logic [OFF_W:0]     nb;
        logic               split;
        logic [DATA_W-1:0]  w0;
        logic [DATA_W-1:0]  rsp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [ADDR_W-1:0] in_waddr;
    logic [OFF_W-1:0]  in_off;
    logic [OFF_W:0]    in_nb;
    logic              in_split;
    logic [DATA_W-1:0] merged;
    logic [DATA_W-1:0] lo_word;

    ula_split_calc #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .OFF_W(OFF_W)) u_calc (
        .addr      (req_addr),
        .size      (req_size),
        .word_addr (in_waddr),
        .off       (in_off),
        .nbytes    (in_nb),
        .split     (in_split)
    );

    assign lo_word = ctl_q.split ? ctl_q.w0 : mem_rd_data;

    ula_merge #(.DATA_W(DATA_W), .NBYTES(NBYTES), .OFF_W(OFF_W)) u_merge (
        .w_lo   (lo_word),
        .w_hi   (mem_rd_data),
        .off    (ctl_q.off),
        .nbytes (ctl_q.nb),
        .split  (ctl_q.split),
        .data   (merged)
    );

    ula_sat_ctr #(.W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (mem_rd_en),
        .count (txn_count)
    );

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_RD0;
                    ctl_d.waddr = in_waddr;
                    ctl_d.off   = in_off;
                    ctl_d.nb    = in_nb;
                    ctl_d.split = in_split;
                end
            end
            ST_RD0:  ctl_d.st = ctl_q.split ? ST_RD1 : ST_FIN;
            ST_RD1: begin
                ctl_d.w0 = mem_rd_data;
                ctl_d.st = ST_FIN;
            end
            ST_FIN: begin
                ctl_d.rsp = merged;
                ctl_d.st  = ST_RESP;
            end
            ST_RESP: ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready   = (ctl_q.st == ST_IDLE);
    assign mem_rd_en   = (ctl_q.st == ST_RD0) || (ctl_q.st == ST_RD1);
    assign mem_rd_addr = (ctl_q.st == ST_RD1) ? (ctl_q.waddr + WSTEP) : ctl_q.waddr;
    assign rsp_valid   = (ctl_q.st == ST_RESP);
    assign rsp_data    = ctl_q.rsp;

endmodule

// File: rtl/ula_load_split_chk.sv
module ula_load_split_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              rsp_valid,
    input logic [CNT_W-1:0]  txn_count
);
    localparam logic [CNT_W-1:0]  CNT_MAX = {CNT_W{1'b1}};
    localparam logic [ADDR_W-1:0] STEP4   = ADDR_W'(4);

    // R1
    rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_rd_addr[1:0] == 2'b00));

    // R2
    second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + STEP4));

    // R2
    max_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en);

    // R6
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R6
    accept_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> mem_rd_en);

    // R8
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mem_rd_en) |-> $stable(txn_count));

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_rd_en) && ($past(txn_count) != CNT_MAX)) |-> (txn_count == $past(txn_count) + CNT_W'(1)));

endmodule

bind ula_load_split ula_load_split_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .rsp_valid   (rsp_valid),
    .txn_count   (txn_count)
);

// File: tb/sim_ula_load_split.sv
`timescale 1ns/1ps
module sim_ula_load_split;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_data;
    logic [CNT_W-1:0]  txn_count;

    always #2.5 clk = ~clk;

    ula_load_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .txn_count(txn_count)
    );

    function automatic logic [7:0] memb(input logic [31:0] a);
        return (a[7:0] * 8'd37) + (a[15:8] * 8'd11) + a[31:24] + 8'h5A;
    endfunction

    function automatic logic [31:0] memw(input logic [31:0] w);
        return {memb(w + 32'd3), memb(w + 32'd2), memb(w + 32'd1), memb(w)};
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memw(mem_rd_addr);

    typedef struct {
        logic [31:0] data;
        logic [31:0] mask;
        logic [31:0] addr;
        logic [1:0]  size;
        int          reads;
        int          acc;
    } exp_t;

    exp_t sb[$];
    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    int model_cnt = 0;
    int n_rd = 0;
    logic [31:0] a0, a1;
    int c0, c1;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en) begin
                if (n_rd == 0) begin a0 = mem_rd_addr; c0 = cyc; end
                else begin a1 = mem_rd_addr; c1 = cyc; end
                n_rd++;
            end
            if (rsp_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R6", "response without request", rsp_data, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(rsp_data == e.data, (e.size == 2'b11) ? "R5" : "R3",
                        "load data", rsp_data, e.data);
                    chk((rsp_data & ~e.mask) == 32'h0, "R4", "zero fill", rsp_data & ~e.mask, 32'h0);
                    chk(n_rd == e.reads, "R2", "read count", n_rd, e.reads);
                    chk(a0 == (e.addr & 32'hFFFF_FFFC), "R1", "first word address", a0, e.addr & 32'hFFFF_FFFC);
                    if (e.reads == 2 && n_rd == 2) begin
                        chk(a1 == a0 + 32'd4, "R2", "second word address", a1, a0 + 32'd4);
                        chk(c1 == c0 + 1, "R2", "reads back to back", c1 - c0, 1);
                    end
                    chk((cyc - e.acc) == ((e.reads == 2) ? 4 : 3), "R7", "latency",
                        cyc - e.acc, (e.reads == 2) ? 4 : 3);
                    chk(!req_ready, "R6", "ready low while responding", req_ready, 0);
                    model_cnt = (model_cnt + e.reads > CMAX) ? CMAX : model_cnt + e.reads;
                    chk(txn_count == CNT_W'(model_cnt), "R8", "transaction count", txn_count, model_cnt);
                end
                n_rd = 0;
            end
        end
    end

    task automatic send(input logic [31:0] addr, input logic [1:0] size, input int hold);
        exp_t e;
        int n;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        n = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
        e.data = 32'h0;
        e.mask = 32'h0;
        for (int i = 0; i < n; i++) begin
            e.data[8*i +: 8] = memb(addr + 32'(i));
            e.mask[8*i +: 8] = 8'hFF;
        end
        e.addr  = addr;
        e.size  = size;
        e.reads = ((int'(addr[1:0]) + n) > 4) ? 2 : 1;
        e.acc   = cyc;
        sb.push_back(e);
        req_valid = 1'b1;
        req_addr  = addr;
        req_size  = size;
        @(negedge clk);
        if (hold > 0) begin
            // R6: a different request held while busy must be ignored
            req_addr = addr ^ 32'h0000_0155;
            req_size = 2'b10;
            repeat (hold) @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int t = 0;
        while (sb.size() != 0 && t < 100) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [31:0] lcg;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9", "ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R9", "rsp_valid in reset", rsp_valid, 0);
        chk(mem_rd_en == 1'b0, "R9", "mem_rd_en in reset", mem_rd_en, 0);
        chk(txn_count == '0, "R9", "count in reset", txn_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && txn_count == '0, "R9", "idle after reset", {req_ready, txn_count}, 9'h100);

        // every offset with every size code (R1 R2 R3 R4 R5)
        for (int off = 0; off < 4; off++)
            for (int sz = 0; sz < 4; sz++)
                send(32'h0000_1230 + 32'(off), 2'(sz), 0);
        drain();

        send(32'h0000_0005, 2'b01, 0);   // halfword inside one word
        send(32'h0000_0001, 2'b10, 0);   // word across a boundary
        send(32'hFFFF_FFFD, 2'b10, 0);   // second word wraps to zero
        send(32'h0000_0102, 2'b10, 3);   // R6 held request while busy
        drain();
        chk(sb.size() == 0, "R6", "all requests answered", sb.size(), 0);

        // back-to-back pseudo-random loads, also saturates the counter (R8)
        lcg = 32'h1234_5678;
        for (int k = 0; k < 260; k++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            send(lcg, lcg[9:8], 0);
        end
        drain();
        chk(txn_count == CNT_W'(CMAX), "R8", "counter saturated", txn_count, CMAX);
        chk(sb.size() == 0, "R6", "no outstanding loads", sb.size(), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule